// File: doc/BRIEF.md
# Banked GPIO Controller with Edge and Level Interrupts

This block gives software control over a wide set of general-purpose pins that are grouped into banks of 32. Through a small word-addressed register bus, software sets each pin's direction and drives its output. Each output is driven high or low through dedicated write-only set and clear words, so no read-modify-write is needed. Software also reads back the conditioned input level of every pin.

Every input passes through a two-flop synchroniser and then a glitch filter. A pin can bypass the filter. The conditioned value feeds an event detector that works in one of two modes:

- **Edge mode:** rising and falling edges are enabled independently.
- **Level mode:** the active polarity is selectable.

Detected events set sticky status bits, which are cleared by writing one. The masked OR of all status bits forms a single interrupt line. A second mask routes events into a separate set of wake status bits, which drive a wake output.

The bus has no back-pressure. Every request is accepted in the cycle it is presented. A read returns its data one cycle later, flagged by `bus_rvalid`.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register holds zero: all pins are inputs (`pad_oe` all 0), `pad_out` is 0, all detection is disabled, and `irq` and `wake` are 0.
- R2: `bus_waddr` is a word index (byte offset / 4). A register of kind K for bank b sits at word (base_K / 4) + b, and bit i of it belongs to pin 32*b + i. The byte bases are:
  - level 0x004 (read-only)
  - direction 0x01C
  - set 0x034 (write-only, reads 0)
  - clear 0x04C (write-only, reads 0)
  - rising-enable 0x064
  - falling-enable 0x07C
  - filter-bypass 0x094
  - interrupt-mask 0x0AC
  - interrupt-status 0x0C4
  - input-type 0x300
  - level-polarity 0x318
  - wake-mask 0x400
  - wake-status 0x418

  A read presented with `bus_req`=1 and `bus_wr`=0 returns data with `bus_rvalid`=1 in the next cycle, and `bus_rvalid` is high at no other time. Writes to the level word are ignored.
- R3: A direction bit of 1 makes the pin an output (`pad_oe` bit 1); 0 makes it an input.
- R4: Writing a 1 to a bit of the set word drives that `pad_out` bit high from the next cycle. Zero bits leave their pins unchanged.
- R5: Writing a 1 to a bit of the clear word drives that `pad_out` bit low from the next cycle. Zero bits leave their pins unchanged.
- R6: Each input is synchronised by two flops. With its bypass bit at 1, the level word shows the synchronised value. With its bypass bit at 0, the value must differ from the filtered output for 3 consecutive clocks before the filtered output follows, so a 2-cycle pulse is dropped and a 3-cycle pulse passes.
- R7: With the input-type bit at 0 (edge mode), a rising edge sets status if the rising-enable bit is 1, and a falling edge sets status if the falling-enable bit is 1. The two enables are independent.
- R8: With the input-type bit at 1 (level mode), status is set in every cycle in which the input is at its active level. The active level is low when the polarity bit is 1 and high when it is 0.
- R9: Status bits are sticky and cleared by writing 1. An event in the same cycle as a clear of that bit leaves the bit set.
- R10: `irq` is 1 exactly when some status bit and its interrupt-mask bit are both 1. A status bit whose mask bit is 0 does not raise `irq`.
- R11: An event on a pin whose wake-mask bit is 1 sets its wake-status bit. That bit is cleared by writing 1, and `wake` is the OR of all wake-status bits. Pins with a wake-mask bit of 0 do not set wake status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, accepted every cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pad_in | input | NUM_BANKS*32 | Raw pad input levels |
| pad_out | output | NUM_BANKS*32 | Output levels |
| pad_oe | output | NUM_BANKS*32 | Output enables (direction register) |
| irq | output | 1 | Combined masked interrupt |
| wake | output | 1 | Combined wake request |

## Verification
A write-one-to-clear of an interrupt-status bit can land in the same clock edge as a new event on the same pin. The bench provokes this with a bypassed pin by releasing a rising edge on the pad exactly two cycles before the clear write. The detector then fires on the very edge that applies the clear. The status word is read back afterwards and must still hold the bit. The same collision is exercised in level mode, where a clear issued while the input stays active must not take effect.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned WADDR_W = 10;

  // word-index bases (byte offset / 4)
  localparam logic [9:0] W_LEVEL = 10'(12'h004 >> 2);
  localparam logic [9:0] W_DIR   = 10'(12'h01C >> 2);
  localparam logic [9:0] W_SET   = 10'(12'h034 >> 2);
  localparam logic [9:0] W_CLR   = 10'(12'h04C >> 2);
  localparam logic [9:0] W_RISE  = 10'(12'h064 >> 2);
  localparam logic [9:0] W_FALL  = 10'(12'h07C >> 2);
  localparam logic [9:0] W_BYP   = 10'(12'h094 >> 2);
  localparam logic [9:0] W_MASK  = 10'(12'h0AC >> 2);
  localparam logic [9:0] W_STAT  = 10'(12'h0C4 >> 2);
  localparam logic [9:0] W_TYPE  = 10'(12'h300 >> 2);
  localparam logic [9:0] W_POL   = 10'(12'h318 >> 2);
  localparam logic [9:0] W_WMASK = 10'(12'h400 >> 2);
  localparam logic [9:0] W_WSTAT = 10'(12'h418 >> 2);

  typedef struct packed {
    logic [BANK_W-1:0] dir;
    logic [BANK_W-1:0] outv;
    logic [BANK_W-1:0] rise_en;
    logic [BANK_W-1:0] fall_en;
    logic [BANK_W-1:0] bypass;
    logic [BANK_W-1:0] mask;
    logic [BANK_W-1:0] lvl_mode;
    logic [BANK_W-1:0] lvl_low;
    logic [BANK_W-1:0] wmask;
  } bank_cfg_t;
endpackage

// File: rtl/gpio_pin_cond.sv
module gpio_pin_cond #(
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad,
  input  logic bypass,
  output logic cond
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q <= pad;
      s2_q <= s1_q;
      if (s2_q != filt_q) begin
        if (cnt_q == LAST) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign cond = bypass ? s2_q : filt_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned BANK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [9:0]        waddr,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] cond,
  output logic [BANK_W-1:0] rdata,
  output logic [BANK_W-1:0] dir,
  output logic [BANK_W-1:0] outv,
  output logic [BANK_W-1:0] bypass,
  output logic              irq_any,
  output logic              wake_any
);
  localparam logic [9:0] BOFS = 10'(BANK);

  bank_cfg_t         cfg_q;
  logic [BANK_W-1:0] stat_q, wstat_q, prev_q;
  logic [BANK_W-1:0] edge_evt, lvl_evt, evt, stat_clr, wstat_clr;

  always_comb begin
    edge_evt = (cond & ~prev_q & cfg_q.rise_en) | (~cond & prev_q & cfg_q.fall_en);
    lvl_evt  = cond ^ cfg_q.lvl_low;
    evt      = (cfg_q.lvl_mode & lvl_evt) | (~cfg_q.lvl_mode & edge_evt);
    stat_clr  = (wr_en && waddr == W_STAT + BOFS)  ? wdata : '0;
    wstat_clr = (wr_en && waddr == W_WSTAT + BOFS) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      stat_q  <= '0;
      wstat_q <= '0;
      prev_q  <= '0;
    end else begin
      prev_q  <= cond;
      stat_q  <= (stat_q & ~stat_clr) | evt;
      wstat_q <= (wstat_q & ~wstat_clr) | (evt & cfg_q.wmask);
      if (wr_en) begin
        if (waddr == W_DIR   + BOFS) cfg_q.dir      <= wdata;
        if (waddr == W_SET   + BOFS) cfg_q.outv     <= cfg_q.outv | wdata;
        if (waddr == W_CLR   + BOFS) cfg_q.outv     <= cfg_q.outv & ~wdata;
        if (waddr == W_RISE  + BOFS) cfg_q.rise_en  <= wdata;
        if (waddr == W_FALL  + BOFS) cfg_q.fall_en  <= wdata;
        if (waddr == W_BYP   + BOFS) cfg_q.bypass   <= wdata;
        if (waddr == W_MASK  + BOFS) cfg_q.mask     <= wdata;
        if (waddr == W_TYPE  + BOFS) cfg_q.lvl_mode <= wdata;
        if (waddr == W_POL   + BOFS) cfg_q.lvl_low  <= wdata;
        if (waddr == W_WMASK + BOFS) cfg_q.wmask    <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (waddr == W_LEVEL + BOFS) rdata = cond;
    if (waddr == W_DIR   + BOFS) rdata = cfg_q.dir;
    if (waddr == W_RISE  + BOFS) rdata = cfg_q.rise_en;
    if (waddr == W_FALL  + BOFS) rdata = cfg_q.fall_en;
    if (waddr == W_BYP   + BOFS) rdata = cfg_q.bypass;
    if (waddr == W_MASK  + BOFS) rdata = cfg_q.mask;
    if (waddr == W_STAT  + BOFS) rdata = stat_q;
    if (waddr == W_TYPE  + BOFS) rdata = cfg_q.lvl_mode;
    if (waddr == W_POL   + BOFS) rdata = cfg_q.lvl_low;
    if (waddr == W_WMASK + BOFS) rdata = cfg_q.wmask;
    if (waddr == W_WSTAT + BOFS) rdata = wstat_q;
  end

  assign dir      = cfg_q.dir;
  assign outv     = cfg_q.outv;
  assign bypass   = cfg_q.bypass;
  assign irq_any  = |(stat_q & cfg_q.mask);
  assign wake_any = |wstat_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 6,
  parameter int unsigned FILT_CYCLES = 3,
  localparam int unsigned NUM_PINS   = NUM_BANKS * BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_wr,
  input  logic [9:0]          bus_waddr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq,
  output logic                wake
);
  logic [BANK_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq, bank_wake;
  logic [NUM_PINS-1:0]  cond, byp;
  logic [31:0] rd_mux, rdata_q;
  logic rvalid_q;
  logic wr_en;

  assign wr_en = bus_req & bus_wr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar i = 0; i < BANK_W; i++) begin : g_pin
      gpio_pin_cond #(.FILT_CYCLES(FILT_CYCLES)) u_cond (
        .clk(clk), .rst_n(rst_n),
        .pad(pad_in[b*BANK_W+i]), .bypass(byp[b*BANK_W+i]),
        .cond(cond[b*BANK_W+i])
      );
    end
    gpio_bank #(.BANK(b)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(bus_waddr),
      .wdata(bus_wdata), .cond(cond[b*BANK_W +: BANK_W]),
      .rdata(bank_rd[b]),
      .dir(pad_oe[b*BANK_W +: BANK_W]),
      .outv(pad_out[b*BANK_W +: BANK_W]),
      .bypass(byp[b*BANK_W +: BANK_W]),
      .irq_any(bank_irq[b]), .wake_any(bank_wake[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_req & ~bus_wr;
      if (bus_req && !bus_wr) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq        = |bank_irq;
  assign wake       = |bank_wake;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_wr,
  input logic [9:0]  bus_waddr,
  input logic [31:0] bus_wdata,
  input logic        bus_rvalid,
  input logic [31:0] out_lo,
  input logic        irq,
  input logic        wake
);
  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_waddr == W_SET) |=> ((out_lo & $past(bus_wdata)) == $past(bus_wdata))); // R4
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_waddr == W_CLR) |=> ((out_lo & $past(bus_wdata)) == 32'h0)); // R5
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvalid); // R2
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_wr)); // R2
  AST_IRQ_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_req && bus_wr)); // R9
  AST_WAKE_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake) |-> $past(bus_req && bus_wr)); // R11
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .out_lo(pad_out[31:0]), .irq(irq), .wake(wake)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  import gpio_pkg::*;
  localparam int NB = 6;
  localparam int NP = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [9:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic irq, wake;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.NUM_BANKS(NB)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq), .wake(wake)
  );

  function automatic logic [9:0] wa(input logic [9:0] base, input int bank);
    return base + 10'(bank);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_req = 1; bus_wr = 1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_req = 1; bus_wr = 0; bus_waddr = a;
    @(negedge clk);
    bus_req = 0;
    if (bus_rvalid !== 1'b1) begin
      nchk++; nerr++;
      $display("FAIL R2 rvalid actual=%b expected=1", bus_rvalid);
    end
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, v, s, model;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wake", {31'b0, wake}, 0);
    chk("R1 oe", {31'b0, |pad_oe}, 0);
    chk("R1 out", {31'b0, |pad_out}, 0);
    rd(wa(W_DIR, 0), d); chk("R1 dir", d, 0);
    rd(wa(W_STAT, 0), d); chk("R1 stat", d, 0);

    // R3 direction
    v = $urandom;
    wr(wa(W_DIR, 1), v);
    rd(wa(W_DIR, 1), d); chk("R3 dir readback", d, v);
    chk("R3 oe", pad_oe[63:32], v);

    // R4 / R5 random set and clear on bank 2
    model = 0;
    for (int k = 0; k < 24; k++) begin
      s = $urandom;
      if ($urandom % 2) begin
        wr(wa(W_SET, 2), s); model = model | s;
        chk("R4 set", pad_out[95:64], model);
      end else begin
        wr(wa(W_CLR, 2), s); model = model & ~s;
        chk("R5 clear", pad_out[95:64], model);
      end
    end

    // R2 map details
    rd(wa(W_SET, 2), d); chk("R2 set reads 0", d, 0);
    wr(wa(W_LEVEL, 0), 32'hFFFF_FFFF);
    rd(wa(W_LEVEL, 0), d); chk("R2 level ignores write", d, 0);
    wr(wa(W_RISE, 5), 32'hA5A5_0001);
    rd(wa(W_RISE, 5), d); chk("R2 bank5 word", d, 32'hA5A5_0001);
    rd(wa(W_RISE, 4), d); chk("R2 bank4 untouched", d, 0);
    wr(wa(W_RISE, 5), 0);

    // R6 random levels: bank 0 bypassed, bank 3 filtered
    wr(wa(W_BYP, 0), 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      v = $urandom;
      pad_in[31:0] = v; pad_in[127:96] = ~v;
      idle(3);
      rd(wa(W_LEVEL, 0), d); chk("R6 bypass level", d, v);
      idle(3);
      rd(wa(W_LEVEL, 3), d); chk("R6 filtered level", d, ~v);
    end
    pad_in[31:0] = 0; pad_in[127:96] = 0;
    idle(8);
    wr(wa(W_STAT, 3), 32'hFFFF_FFFF);
    wr(wa(W_RISE, 3), 1);
    pad_in[96] = 1; idle(2); pad_in[96] = 0; idle(8);
    rd(wa(W_STAT, 3), d); chk("R6 2-cycle glitch dropped", d, 0);
    pad_in[96] = 1; idle(3); pad_in[96] = 0; idle(8);
    rd(wa(W_STAT, 3), d); chk("R6 3-cycle pulse passes", d, 1);

    // R6/R10 bypass latency to irq
    wr(wa(W_MASK, 0), 1);
    wr(wa(W_RISE, 0), 1);
    pad_in[0] = 1;
    @(negedge clk); @(negedge clk);
    chk("R6 irq not before 3rd edge", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R10 irq after rising edge", {31'b0, irq}, 1);
    rd(wa(W_STAT, 0), d); chk("R7 rise status", d, 1);

    // R9 clear
    wr(wa(W_STAT, 0), 1);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    rd(wa(W_STAT, 0), d); chk("R9 status cleared", d, 0);

    // R9 clear colliding with a new edge
    pad_in[0] = 0; idle(5);
    wr(wa(W_STAT, 0), 32'hFFFF_FFFF);
    pad_in[0] = 1;
    @(negedge clk); @(negedge clk);
    wr(wa(W_STAT, 0), 1);
    rd(wa(W_STAT, 0), d); chk("R9 event wins over clear", d, 1);
    wr(wa(W_STAT, 0), 1);

    // R7 falling edge only on bit 1
    wr(wa(W_FALL, 0), 2);
    wr(wa(W_MASK, 0), 3);
    pad_in[1] = 1; idle(5);
    rd(wa(W_STAT, 0), d); chk("R7 rise ignored on fall-only pin", d, 0);
    pad_in[1] = 0; idle(5);
    rd(wa(W_STAT, 0), d); chk("R7 fall status", d, 2);
    chk("R10 irq on fall", {31'b0, irq}, 1);
    wr(wa(W_STAT, 0), 2);

    // R7 both edges on bit 4 (unmasked -> R10)
    wr(wa(W_RISE, 0), 32'h11);
    wr(wa(W_FALL, 0), 32'h12);
    pad_in[4] = 1; idle(5);
    rd(wa(W_STAT, 0), d); chk("R7 both: rise", d, 32'h10);
    chk("R10 masked pin no irq", {31'b0, irq}, 0);
    wr(wa(W_STAT, 0), 32'h10);
    pad_in[4] = 0; idle(5);
    rd(wa(W_STAT, 0), d); chk("R7 both: fall", d, 32'h10);
    wr(wa(W_STAT, 0), 32'h10);

    // R8 level, active low on bit 2
    wr(wa(W_POL, 0), 4);
    wr(wa(W_TYPE, 0), 4);
    idle(4);
    rd(wa(W_STAT, 0), d); chk("R8 active-low level", d, 4);
    wr(wa(W_STAT, 0), 4);
    rd(wa(W_STAT, 0), d); chk("R9 level re-asserts over clear", d, 4);
    pad_in[2] = 1; idle(5);
    wr(wa(W_STAT, 0), 4);
    rd(wa(W_STAT, 0), d); chk("R8 inactive level clears", d, 0);
    // active high on bit 3
    wr(wa(W_TYPE, 0), 32'hC);
    idle(4);
    rd(wa(W_STAT, 0), d); chk("R8 active-high idle", d, 0);
    pad_in[3] = 1; idle(5);
    rd(wa(W_STAT, 0), d); chk("R8 active-high level", d, 8);
    wr(wa(W_TYPE, 0), 0);
    wr(wa(W_POL, 0), 0);
    wr(wa(W_STAT, 0), 32'hFFFF_FFFF);
    rd(wa(W_STAT, 0), d); chk("R9 all cleared", d, 0);

    // R11 wake
    wr(wa(W_WMASK, 0), 1);
    pad_in[0] = 0; idle(5);
    pad_in[0] = 1; idle(4);
    chk("R11 wake set", {31'b0, wake}, 1);
    rd(wa(W_WSTAT, 0), d); chk("R11 wake status", d, 1);
    wr(wa(W_WSTAT, 0), 1);
    chk("R11 wake cleared", {31'b0, wake}, 0);
    pad_in[1] = 1; idle(5); pad_in[1] = 0; idle(5);
    chk("R11 unmasked wake pin", {31'b0, wake}, 0);
    rd(wa(W_WSTAT, 0), d); chk("R11 wake status stays 0", d, 0);

    finish_run();
  end
endmodule